// File: doc/BRIEF.md
# Serial Flash Slave Model

This block behaves as a serial-interface flash memory in SPI mode 0, for use wherever a design needs a flash device it can talk to. It is built to be synthesized. It holds a byte array whose size is set by a parameter. It samples the chip select, serial clock and serial data input on its own system clock. Each command starts with an 8-bit opcode. Commands that use an address follow it with a 24-bit address, most significant bit first. The array is split into equal sectors, and each sector is split into 256-byte pages.

The model covers the common command set: setting and clearing write permission, reading and writing the status byte, sequential read, page program, sector erase, bulk erase, and an identification read. Program, erase and status writes are committed only when chip select goes high. Each one then runs as a self-timed job that walks the affected bytes one system clock at a time, with the busy flag set for the whole job. Two status bits set how many of the top sectors are protected against program and erase.

Top module: `flash_slave`

## Requirements
- R1: After reset the status byte reads 0x00. Its layout is bit 0 = busy, bit 1 = write permission, bits 3:2 = protect level, and bits 7:4 always read 0. Opcode 0x05 shifts the status byte out, repeated for as long as the clock runs.
- R2: Opcode 0x06 sets write permission (status bit 1). Opcode 0x04 clears it.
- R3: Page program, sector erase, bulk erase and status write are ignored when write permission is clear. The array and the status byte are left unchanged.
- R4: Status bit 0 reads 1 while a committed program, erase or status-write job runs, and 0 once it has finished. Write permission is cleared when the job finishes.
- R5: Opcode 0x03 followed by a 24-bit address returns the data byte at that address, most significant bit first. It then moves on to each following address for as long as the clock runs. Address bits above the array size are ignored.
- R6: After reset every byte of the array reads 0xFF.
- R7: Opcode 0x02 with an address, then data bytes, ANDs each byte into the array. The column index wraps inside the 256-byte page. Bytes of the page that received no data stay unchanged.
- R8: A program or erase is committed only if chip select rises on a byte boundary. Otherwise the array is unchanged and write permission stays set.
- R9: Opcode 0xD8 with an address sets every byte of the addressed sector to 0xFF and leaves the other sectors unchanged.
- R10: Opcode 0xC7 sets every byte of the array to 0xFF.
- R11: Opcode 0x01 followed by a byte loads the protect level from bits 3:2 of that byte. With four sectors, level 0 protects nothing, level 1 protects sector 3, level 2 protects sectors 2 and 3, and level 3 protects all sectors.
- R12: A program or sector erase that targets a protected sector, or a bulk erase while the protect level is not 0, is dropped. The array is unchanged, the busy bit does not rise, and write permission is cleared.
- R13: Opcode 0xAB followed by three dummy bytes shifts out the identification byte (default 0x12), repeated until chip select goes high.
- R14: While the busy bit is set, every opcode except 0x05 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_sdi | input | 1 | Serial data into the block, sampled on the rising serial clock edge |
| spi_sdo | output | 1 | Serial data out of the block, changed on the falling serial clock edge |

## Verification
The bench builds the block with its default parameters: a 2048-byte array, four 512-byte sectors, 256-byte pages and a 16-cycle status write. With four sectors, every protect level has a clear boundary between protected and writable sectors. The small array keeps a bulk-erase walk at 2048 cycles, so the bench can issue commands while the job is still running and then watch it finish. Because the array has 11 address bits, a read with the top address byte all ones checks that the unused address bits are ignored.

// File: rtl/flash_slave_pkg.sv
package flash_slave_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_SERS = 8'hD8;
    localparam logic [7:0] OP_BERS = 8'hC7;
    localparam logic [7:0] OP_RDID = 8'hAB;

    // Position inside the current chip-select frame.
    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_e;

    // Self-timed job, either pending (waiting for chip select high) or running.
    typedef enum logic [2:0] {
        JOB_NONE,
        JOB_PROG,
        JOB_SECT,
        JOB_BULK,
        JOB_STAT
    } job_e;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int DEPTH = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [7:0]               rdata
);
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= 8'hFF;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

    // R7: stored bits only go from 1 to 0 on a program write or get set again by an erase
    // (an erase writes 0xFF)
    erase_or_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ((wdata == 8'hFF) || ((wdata & ~cells_q[waddr]) == 8'h00)));

endmodule

// File: rtl/flash_pagebuf.sv
module flash_pagebuf #(
    parameter int PAGE = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    we,
    input  logic [$clog2(PAGE)-1:0] widx,
    input  logic [7:0]              wdata,
    input  logic [$clog2(PAGE)-1:0] ridx,
    output logic [7:0]              rdata,
    output logic                    rvalid
);
    logic [7:0]      data_q [PAGE];
    logic [PAGE-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (we) data_q[widx] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     valid_q       <= '0;
        else if (clr)   valid_q       <= '0;
        else if (we)    valid_q[widx] <= 1'b1;
    end

    assign rdata  = data_q[ridx];
    assign rvalid = valid_q[ridx];

    // R7: a new program command and a data byte never arrive in the same cycle
    clr_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(clr && we));

endmodule

// File: rtl/flash_slave.sv
module flash_slave
    import flash_slave_pkg::*;
#(
    parameter int          MEM_BYTES    = 2048,
    parameter int          SECTOR_BYTES = 512,
    parameter int          PAGE_BYTES   = 256,
    parameter int          WRSR_CYCLES  = 16,
    parameter logic [7:0]  ID_BYTE      = 8'h12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_sdi,
    output logic spi_sdo
);
    localparam int AW      = $clog2(MEM_BYTES);
    localparam int SW      = $clog2(SECTOR_BYTES);
    localparam int PW      = $clog2(PAGE_BYTES);
    localparam int SECTORS = MEM_BYTES / SECTOR_BYTES;
    localparam int SECW    = $clog2(SECTORS);
    localparam int CW      = AW + 1;

    typedef struct packed {
        logic          sck_q, sck_qq, cs_q, cs_qq, sdi_q;
        phase_e        phase;
        logic [2:0]    bitcnt;
        logic [1:0]    bytecnt;
        logic [7:0]    shreg;
        logic [7:0]    opcode;
        logic [7:0]    tx;
        logic          sdo;
        logic [23:0]   addr;
        logic          wel, wip;
        logic [1:0]    bp, bp_new;
        job_e          pend, job;
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
    } st_t;

    st_t q, d;

    logic          sck_rise, sck_fall, cs_rise;
    logic [7:0]    byte_in, status, mem_rdata, mem_wdata, pb_rdata;
    logic [AW-1:0] walk_addr, mem_raddr;
    logic          mem_we, pb_we, pb_clr, pb_valid, wr_prot;

    function automatic logic sect_prot(input logic [1:0] lvl, input logic [SECW-1:0] sec);
        int unsigned nprot;
        case (lvl)
            2'd0:    nprot = 0;
            2'd3:    nprot = SECTORS;
            default: nprot = 32'(SECTORS) >> (2'd3 - lvl);
        endcase
        return (32'(sec) + nprot) >= 32'(SECTORS);
    endfunction

    function automatic logic [CW-1:0] job_len(input job_e j);
        case (j)
            JOB_PROG: return CW'(PAGE_BYTES);
            JOB_SECT: return CW'(SECTOR_BYTES);
            JOB_BULK: return CW'(MEM_BYTES);
            default:  return CW'(WRSR_CYCLES);
        endcase
    endfunction

    assign sck_rise  = q.sck_q & ~q.sck_qq & ~q.cs_q;
    assign sck_fall  = ~q.sck_q & q.sck_qq & ~q.cs_q;
    assign cs_rise   = q.cs_q & ~q.cs_qq;
    assign byte_in   = {q.shreg[6:0], q.sdi_q};
    assign status    = {4'b0000, q.bp, q.wel, q.wip};
    assign walk_addr = q.base + q.cnt[AW-1:0];
    assign mem_raddr = (q.job != JOB_NONE) ? walk_addr : q.addr[AW-1:0];
    assign wr_prot   = sect_prot(q.bp, walk_addr[AW-1:SW]);
    assign spi_sdo   = q.sdo;

    flash_array #(.DEPTH(MEM_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(walk_addr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    flash_pagebuf #(.PAGE(PAGE_BYTES)) u_pagebuf (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we), .widx(q.addr[PW-1:0]),
        .wdata(byte_in), .ridx(q.cnt[PW-1:0]), .rdata(pb_rdata), .rvalid(pb_valid)
    );

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_wdata = 8'hFF;
        pb_we     = 1'b0;
        pb_clr    = 1'b0;
        d.sck_q   = spi_sck;
        d.sck_qq  = q.sck_q;
        d.cs_q    = spi_cs_n;
        d.cs_qq   = q.cs_q;
        d.sdi_q   = spi_sdi;

        // Self-timed job: one byte per system clock.
        if (q.job != JOB_NONE) begin
            case (q.job)
                JOB_PROG: begin
                    mem_we    = pb_valid;
                    mem_wdata = mem_rdata & pb_rdata;
                end
                JOB_SECT, JOB_BULK: mem_we = 1'b1;
                default: ;
            endcase
            if (q.cnt == job_len(q.job) - 1'b1) begin
                d.job = JOB_NONE;
                d.wip = 1'b0;
                d.wel = 1'b0;
                if (q.job == JOB_STAT) d.bp = q.bp_new;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (q.cs_q) begin
            d.phase  = PH_CMD;
            d.bitcnt = 3'd0;
            d.sdo    = 1'b0;
            d.pend   = JOB_NONE;
            if (cs_rise && q.pend != JOB_NONE && q.bitcnt == 3'd0) begin
                d.cnt = '0;
                case (q.pend)
                    JOB_PROG: begin
                        d.base = {q.addr[AW-1:PW], {PW{1'b0}}};
                        if (sect_prot(q.bp, q.addr[AW-1:SW])) d.wel = 1'b0;
                        else begin d.job = JOB_PROG; d.wip = 1'b1; end
                    end
                    JOB_SECT: begin
                        d.base = {q.addr[AW-1:SW], {SW{1'b0}}};
                        if (sect_prot(q.bp, q.addr[AW-1:SW])) d.wel = 1'b0;
                        else begin d.job = JOB_SECT; d.wip = 1'b1; end
                    end
                    JOB_BULK: begin
                        d.base = '0;
                        if (q.bp != 2'd0) d.wel = 1'b0;
                        else begin d.job = JOB_BULK; d.wip = 1'b1; end
                    end
                    default: begin d.job = JOB_STAT; d.wip = 1'b1; end
                endcase
            end
        end else if (sck_rise) begin
            d.shreg  = byte_in;
            d.bitcnt = q.bitcnt + 1'b1;
            if (q.bitcnt == 3'd7) begin
                case (q.phase)
                    PH_CMD: begin
                        d.opcode  = byte_in;
                        d.bytecnt = 2'd0;
                        d.phase   = PH_SKIP;
                        if (!q.wip || byte_in == OP_RDSR) begin
                            case (byte_in)
                                OP_WREN: d.wel = 1'b1;
                                OP_WRDI: d.wel = 1'b0;
                                OP_RDSR: d.phase = PH_DATA;
                                OP_WRSR: if (q.wel) d.phase = PH_DATA;
                                OP_READ: d.phase = PH_ADDR;
                                OP_PROG: if (q.wel) begin d.phase = PH_ADDR; pb_clr = 1'b1; end
                                OP_SERS: if (q.wel) d.phase = PH_ADDR;
                                OP_BERS: if (q.wel) d.pend = JOB_BULK;
                                OP_RDID: d.phase = PH_DUMMY;
                                default: ;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        d.addr    = {q.addr[15:0], byte_in};
                        d.bytecnt = q.bytecnt + 1'b1;
                        if (q.bytecnt == 2'd2) begin
                            case (q.opcode)
                                OP_READ: d.phase = PH_DATA;
                                OP_PROG: begin d.phase = PH_DATA; d.pend = JOB_PROG; end
                                default: begin d.phase = PH_SKIP; d.pend = JOB_SECT; end
                            endcase
                        end
                    end
                    PH_DUMMY: begin
                        d.bytecnt = q.bytecnt + 1'b1;
                        if (q.bytecnt == 2'd2) d.phase = PH_DATA;
                    end
                    PH_DATA: begin
                        if (q.opcode == OP_WRSR) begin
                            d.bp_new = byte_in[3:2];
                            d.pend   = JOB_STAT;
                            d.phase  = PH_SKIP;
                        end else if (q.opcode == OP_PROG) begin
                            pb_we             = 1'b1;
                            d.addr[PW-1:0]    = q.addr[PW-1:0] + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (sck_fall && q.phase == PH_DATA &&
                     (q.opcode == OP_READ || q.opcode == OP_RDSR || q.opcode == OP_RDID)) begin
            if (q.bitcnt == 3'd0) begin
                case (q.opcode)
                    OP_READ: begin d.sdo = mem_rdata[7]; d.tx = {mem_rdata[6:0], 1'b0};
                                   d.addr = q.addr + 24'd1; end
                    OP_RDSR: begin d.sdo = status[7];    d.tx = {status[6:0], 1'b0}; end
                    default: begin d.sdo = ID_BYTE[7];   d.tx = {ID_BYTE[6:0], 1'b0}; end
                endcase
            end else begin
                d.sdo = q.tx[7];
                d.tx  = {q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs_q  <= 1'b1;
            q.cs_qq <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R4
    wel_held_chk: assert property (@(posedge clk) disable iff (!rst_n) q.wip |-> q.wel);
    // R3
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wip) |-> $past(q.wel));
    // R8
    start_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wip) |-> $past(cs_rise));
    // R11
    bp_after_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.bp) |-> $past(q.wip));
    // R12
    no_prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wr_prot);

endmodule

// File: tb/flash_slave_tb.sv
module flash_slave_tb;
    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo;
    int   checks = 0, fails = 0;
    logic [7:0] rbuf [4];
    logic [7:0] st;

    always #5 clk = ~clk;

    flash_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi), .spi_sdo(sdo)
    );

    // {address[15:0], program byte, expected read-back}
    localparam logic [31:0] VEC [6] = '{
        {16'h0010, 8'hF0, 8'hF0},
        {16'h0010, 8'h3C, 8'h30},
        {16'h0123, 8'hA5, 8'hA5},
        {16'h0123, 8'hFF, 8'hA5},
        {16'h05FF, 8'h00, 8'h00},
        {16'h0702, 8'h7E, 8'h7E}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic shift(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            sdi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = sdo;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] dummy;
        shift(a[23:16], 8, dummy);
        shift(a[15:8], 8, dummy);
        shift(a[7:0], 8, dummy);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] dummy;
        sel(); shift(op, 8, dummy); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] dummy;
        sel(); shift(8'h05, 8, dummy); shift(8'h00, 8, s); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] dummy;
        sel(); shift(8'h01, 8, dummy); shift(v, 8, dummy); desel();
    endtask

    task automatic prog(input logic [23:0] a, input int n, input logic [7:0] b0,
                        input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] dummy;
        sel(); shift(8'h02, 8, dummy); send_addr(a);
        if (n > 0) shift(b0, 8, dummy);
        if (n > 1) shift(b1, 8, dummy);
        if (n > 2) shift(b2, 8, dummy);
        desel();
    endtask

    task automatic erase_sector(input logic [23:0] a);
        logic [7:0] dummy;
        sel(); shift(8'hD8, 8, dummy); send_addr(a); desel();
    endtask

    task automatic rd(input logic [23:0] a, input int n);
        logic [7:0] dummy, v;
        sel(); shift(8'h03, 8, dummy); send_addr(a);
        for (int k = 0; k < n; k++) begin
            shift(8'h00, 8, v);
            rbuf[k] = v;
        end
        desel();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        s = 8'h01;
        for (int k = 0; k < 100 && s[0]; k++) rdsr(s);
        chk("R4 busy bit returns to 0", {7'd0, s[0]}, 8'h00);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] dummy;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset status, R6 erased array
        rdsr(st);          chk("R1 status after reset", st, 8'h00);
        rd(24'h000000, 1); chk("R6 first byte erased", rbuf[0], 8'hFF);
        rd(24'h0007FF, 1); chk("R6 last byte erased", rbuf[0], 8'hFF);

        // R2 write permission set and clear
        cmd1(8'h06); rdsr(st); chk("R2 set write permission", st, 8'h02);
        cmd1(8'h04); rdsr(st); chk("R2 clear write permission", st, 8'h00);

        // R3 commands without write permission
        prog(24'h000040, 1, 8'hAA, 8'h00, 8'h00);
        rd(24'h000040, 1); chk("R3 program ignored", rbuf[0], 8'hFF);
        wrsr(8'h0C); rdsr(st); chk("R3 status write ignored", st, 8'h00);

        // R7 vector table
        for (int i = 0; i < 6; i++) begin
            cmd1(8'h06);
            prog({8'h00, VEC[i][31:16]}, 1, VEC[i][15:8], 8'h00, 8'h00);
            wait_idle();
            rd({8'h00, VEC[i][31:16]}, 1);
            chk("R7 program AND vector", rbuf[0], VEC[i][7:0]);
        end

        // R4 busy during program, permission cleared afterwards
        cmd1(8'h06);
        prog(24'h000080, 1, 8'h55, 8'h00, 8'h00);
        rdsr(st); chk("R4 busy and permission during program", st, 8'h03);
        wait_idle();
        rdsr(st); chk("R4 permission cleared after job", st, 8'h00);
        rd(24'h000080, 1); chk("R4 programmed byte", rbuf[0], 8'h55);

        // R7 page wrap, R5 sequential read
        cmd1(8'h06);
        prog(24'h0001FE, 3, 8'h11, 8'h22, 8'h33);
        wait_idle();
        rd(24'h0001FE, 3);
        chk("R5 sequential byte 0", rbuf[0], 8'h11);
        chk("R5 sequential byte 1", rbuf[1], 8'h22);
        chk("R5 sequential crosses page", rbuf[2], 8'hFF);
        rd(24'h000100, 2);
        chk("R7 wrapped byte at page start", rbuf[0], 8'h33);
        chk("R7 untouched byte in page", rbuf[1], 8'hFF);
        rd(24'hFFF1FE, 1); chk("R5 upper address bits ignored", rbuf[0], 8'h11);

        // R8 chip select rising mid-byte
        cmd1(8'h06);
        sel(); shift(8'h02, 8, dummy); send_addr(24'h000300); shift(8'h00, 4, dummy); desel();
        rd(24'h000300, 1); chk("R8 partial byte not committed", rbuf[0], 8'hFF);
        rdsr(st); chk("R8 permission kept", st, 8'h02);
        cmd1(8'h04);

        // R13 identification
        sel(); shift(8'hAB, 8, dummy);
        for (int k = 0; k < 3; k++) shift(8'h00, 8, dummy);
        shift(8'h00, 8, st); chk("R13 id byte", st, 8'h12);
        shift(8'h00, 8, st); chk("R13 id repeats", st, 8'h12);
        desel();

        // R11 protect level 1, R12 drops
        cmd1(8'h06); wrsr(8'h04); wait_idle();
        rdsr(st); chk("R11 protect level loaded", st, 8'h04);
        cmd1(8'h06); prog(24'h000700, 1, 8'h00, 8'h00, 8'h00);
        rd(24'h000700, 1); chk("R12 protected program dropped", rbuf[0], 8'hFF);
        rdsr(st); chk("R12 permission cleared on drop", st, 8'h04);
        cmd1(8'h06); prog(24'h000500, 1, 8'h0F, 8'h00, 8'h00); wait_idle();
        rd(24'h000500, 1); chk("R11 sector 2 writable at level 1", rbuf[0], 8'h0F);

        cmd1(8'h06); wrsr(8'h08); wait_idle();
        cmd1(8'h06); erase_sector(24'h000500);
        rd(24'h000500, 1); chk("R12 protected erase dropped", rbuf[0], 8'h0F);
        cmd1(8'h06); cmd1(8'hC7);
        rdsr(st); chk("R12 bulk erase dropped", st, 8'h08);
        rd(24'h000010, 1); chk("R12 bulk erase left data", rbuf[0], 8'h30);

        // R9 sector erase
        cmd1(8'h06); wrsr(8'h00); wait_idle();
        cmd1(8'h06); erase_sector(24'h000123); wait_idle();
        rd(24'h000123, 1); chk("R9 erased in sector", rbuf[0], 8'hFF);
        rd(24'h000010, 1); chk("R9 erased whole sector", rbuf[0], 8'hFF);
        rd(24'h000500, 1); chk("R9 other sector kept", rbuf[0], 8'h0F);

        // R10 bulk erase, R14 commands ignored while busy
        cmd1(8'h06); cmd1(8'hC7);
        cmd1(8'h04);
        rdsr(st); chk("R14 clear ignored while busy", st, 8'h03);
        wait_idle();
        rd(24'h000500, 1); chk("R10 bulk erased sector 2", rbuf[0], 8'hFF);
        rd(24'h000702, 1); chk("R10 bulk erased sector 3", rbuf[0], 8'hFF);

        summary();
        $finish;
    end
endmodule